// File: doc/BRIEF.md
# Accumulator Processing Element

This block is the accumulator slice of a processor whose registers are independent processing elements. Each element holds its own value and its own carry and zero flags and runs one operation per clock, picked by a 3-bit code taken directly from the instruction word. The accumulator does add and subtract with carry, rotate right through carry, XOR, AND, load and store. The operand always arrives on the shared internal data bus.

Incoming carry and zero flags come from the surrounding flag path. The element registers the updated flags on the same edge as its value. An operation that does not touch a flag copies the incoming flag to the output flag, so the flags survive a cycle in which they are not used.

For a store, the element raises a drive enable and places its value on a bus output. That output is zero at all other times, so several elements can be combined with a wide OR. An activity output goes low only for the no-op code, which lets the surrounding logic count how many elements did work in a cycle.

Top module: `accum_pe`

## Requirements
- R1: On a rising clock edge with `rst_n` low, the accumulator, the carry flag and the zero flag all become 0, whatever the other inputs are.
- R2: Code 0 is the no-op: the accumulator holds its value, `carry_out` takes `carry_in` and `zero_out` takes `zero_in`.
- R3: Code 5 is add with carry: {carry, accumulator} becomes accumulator + `bus_in` + `carry_in`, computed as a 17-bit sum.
- R4: Code 2 is subtract with carry: {carry, accumulator} becomes accumulator + (`bus_in` XOR 0xFFFF) + `carry_in`, computed as a 17-bit sum, so a carry of 1 means no borrow.
- R5: Code 3 is rotate right through carry: the new accumulator is {`carry_in`, accumulator[15:1]} and the new carry is the old accumulator[0].
- R6: Codes 1 (XOR), 6 (AND) and 4 (load) set the accumulator to accumulator XOR `bus_in`, accumulator AND `bus_in` and `bus_in` respectively, and copy `carry_in` to the carry flag.
- R7: For codes 1 through 6 the zero flag becomes 1 exactly when the new 16-bit accumulator is 0x0000, whatever `zero_in` is.
- R8: Code 7 is store: `drive_en` is 1 and `bus_drive` carries the current accumulator in the same cycle; the accumulator and flags behave as for the no-op.
- R9: For every code other than 7, `drive_en` is 0 and `bus_drive` is 0x0000.
- R10: `active` is 0 when `op_code` is 0 and 1 for every other code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 3 | Operation select for this cycle |
| bus_in | input | 16 | Operand from the internal data bus |
| carry_in | input | 1 | Incoming carry flag |
| zero_in | input | 1 | Incoming zero flag |
| acc_out | output | 16 | Registered accumulator value |
| carry_out | output | 1 | Registered carry flag |
| zero_out | output | 1 | Registered zero flag |
| drive_en | output | 1 | High when the element drives data onto the bus |
| bus_drive | output | 16 | Value for the OR bus; zero unless storing |
| active | output | 1 | Low only for the no-op |

## Verification
The arithmetic codes are run with operands that produce an exact 0x10000 wrap, sums with and without carry-in, a subtraction that borrows and one that does not. These separate the carry taken from bit 16 from the carry-in, and they show that the zero flag comes from the result and not from the carry. The rotates use a carry-in of 1 and of 0 on values whose low bit is set, including one that leaves a zero result, so the two ends of the 17-bit ring are told apart. XOR, AND and load run with `carry_in` and `zero_in` set opposite to what the result would imply, which shows which flag each code updates and which it copies. The no-op and store follow a nonzero accumulator, which checks the bus gating. A reset during a load checks that reset wins.

// File: rtl/accum_pe_pkg.sv
// Package: shared types of the accumulator processing element.
// Assumes: the operation code is a 3-bit field taken from the instruction word.
package accum_pe_pkg;

    // Operation codes; the values are fixed by the instruction encoding.
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_XOR   = 3'd1,
        OP_SUBC  = 3'd2,
        OP_ROTR  = 3'd3,
        OP_LOAD  = 3'd4,
        OP_ADDC  = 3'd5,
        OP_AND   = 3'd6,
        OP_DRIVE = 3'd7
    } op_e;

    // Flag pair owned by the element.
    typedef struct packed {
        logic carry;
        logic zero;
    } flags_t;

endpackage

// File: rtl/accum_pe_adder.sv
// Module: accum_pe_adder
// Adds a, b (optionally inverted) and a carry-in, and returns a W-bit sum plus
// the carry out of the top bit.
// Assumes: the caller chooses inversion for subtract-with-carry.
module accum_pe_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    localparam int SW = W + 1;

    logic [W-1:0]  b_eff;
    logic [SW-1:0] total;

    // Operand conditioning: ones' complement for subtraction.
    always_comb begin
        b_eff = invert_b ? ~b : b;
    end

    // Wide sum so the carry out is bit W.
    always_comb begin
        total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    end

    assign sum  = total[W-1:0];
    assign cout = total[W];

endmodule

// File: rtl/accum_pe_next.sv
// Module: accum_pe_next
// Computes the next accumulator value and next flags for one operation.
// Assumes: the flags that an operation does not affect are copied from the incoming flags.
module accum_pe_next
    import accum_pe_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e          op,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] data,
    input  flags_t       flags_in,
    output logic [W-1:0] acc_next,
    output flags_t       flags_next
);

    logic [W-1:0] add_sum;
    logic         add_cout;
    logic         use_invert;

    // Inversion is selected only for subtract-with-carry.
    always_comb begin
        use_invert = (op == OP_SUBC);
    end

    accum_pe_adder #(.W(W)) u_adder (
        .a        (acc),
        .b        (data),
        .invert_b (use_invert),
        .cin      (flags_in.carry),
        .sum      (add_sum),
        .cout     (add_cout)
    );

    // Result and flag selection per operation.
    always_comb begin
        acc_next   = acc;
        flags_next = flags_in;
        unique case (op)
            OP_HOLD, OP_DRIVE: begin
                acc_next   = acc;
                flags_next = flags_in;
            end
            OP_XOR: begin
                acc_next        = acc ^ data;
                flags_next.zero = ~|(acc ^ data);
            end
            OP_AND: begin
                acc_next        = acc & data;
                flags_next.zero = ~|(acc & data);
            end
            OP_LOAD: begin
                acc_next        = data;
                flags_next.zero = ~|data;
            end
            OP_ADDC, OP_SUBC: begin
                acc_next         = add_sum;
                flags_next.carry = add_cout;
                flags_next.zero  = ~|add_sum;
            end
            OP_ROTR: begin
                acc_next         = {flags_in.carry, acc[W-1:1]};
                flags_next.carry = acc[0];
                flags_next.zero  = ~|{flags_in.carry, acc[W-1:1]};
            end
            default: begin
                acc_next   = acc;
                flags_next = flags_in;
            end
        endcase
    end

endmodule

// File: rtl/accum_pe_bus.sv
// Module: accum_pe_bus
// Produces the data-drive enable, the gated bus value and the activity signal.
// Assumes: the bus outside the element ORs all drivers, so an idle driver must output zero.
module accum_pe_bus
    import accum_pe_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e          op,
    input  logic [W-1:0] acc,
    output logic         drive_en,
    output logic [W-1:0] bus_drive,
    output logic         active
);

    // Decode the store and the no-op.
    always_comb begin
        drive_en = (op == OP_DRIVE);
        active   = (op != OP_HOLD);
    end

    // Per-bit AND gate onto the OR bus.
    for (genvar i = 0; i < W; i++) begin : g_gate
        assign bus_drive[i] = acc[i] & drive_en;
    end

endmodule

// File: rtl/accum_pe.sv
// Module: accum_pe (top)
// Accumulator processing element: register, own carry/zero flags, ALU and bus gate.
// Assumes: synchronous active-low reset; the operand arrives on bus_in in the cycle the
// operation is presented; the flags are registered together with the value.
module accum_pe
    import accum_pe_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   op_code,
    input  logic [W-1:0] bus_in,
    input  logic         carry_in,
    input  logic         zero_in,
    output logic [W-1:0] acc_out,
    output logic         carry_out,
    output logic         zero_out,
    output logic         drive_en,
    output logic [W-1:0] bus_drive,
    output logic         active
);

    op_e          op_sel;
    logic [W-1:0] acc_q;
    logic [W-1:0] acc_d;
    flags_t       flags_q;
    flags_t       flags_d;
    flags_t       flags_in;

    // Map the raw code and the incoming flags to internal types.
    always_comb begin
        op_sel         = op_e'(op_code);
        flags_in.carry = carry_in;
        flags_in.zero  = zero_in;
    end

    accum_pe_next #(.W(W)) u_next (
        .op         (op_sel),
        .acc        (acc_q),
        .data       (bus_in),
        .flags_in   (flags_in),
        .acc_next   (acc_d),
        .flags_next (flags_d)
    );

    accum_pe_bus #(.W(W)) u_bus (
        .op        (op_sel),
        .acc       (acc_q),
        .drive_en  (drive_en),
        .bus_drive (bus_drive),
        .active    (active)
    );

    // State register for the value and the flags, with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            flags_q <= '0;
        end else begin
            acc_q   <= acc_d;
            flags_q <= flags_d;
        end
    end

    assign acc_out   = acc_q;
    assign carry_out = flags_q.carry;
    assign zero_out  = flags_q.zero;

endmodule

// File: rtl/accum_pe_checker.sv
// Module: accum_pe_checker
// Property checks on the ports of accum_pe; attached with the bind below.
// Assumes: the same parameter W as the bound instance.
module accum_pe_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   op_code,
    input logic [W-1:0] bus_in,
    input logic         carry_in,
    input logic         zero_in,
    input logic [W-1:0] acc_out,
    input logic         carry_out,
    input logic         zero_out,
    input logic         drive_en,
    input logic [W-1:0] bus_drive,
    input logic         active
);

    // R1: reset clears value and flags on the next edge
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (acc_out == '0) && !carry_out && !zero_out);

    // R2: no-op holds value and passes the flags through
    a_r2_hold_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd0) |=> (acc_out == $past(acc_out)) &&
            (carry_out == $past(carry_in)) && (zero_out == $past(zero_in)));

    // R3: add with carry gives a 17-bit sum
    a_r3_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd5) |=> ({carry_out, acc_out} ==
            ({1'b0, $past(acc_out)} + {1'b0, $past(bus_in)} + {{W{1'b0}}, $past(carry_in)})));

    // R4: subtract with carry adds the ones' complement
    a_r4_sub_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd2) |=> ({carry_out, acc_out} ==
            ({1'b0, $past(acc_out)} + {1'b0, ~$past(bus_in)} + {{W{1'b0}}, $past(carry_in)})));

    // R5: rotate moves bit 0 into carry and carry into the top bit
    a_r5_rotate_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd3) |=> (carry_out == $past(acc_out[0])) &&
            (acc_out[W-1] == $past(carry_in)) && (acc_out[W-2:0] == $past(acc_out[W-1:1])));

    // R6: load copies the operand and leaves carry from the input
    a_r6_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd4) |=> (acc_out == $past(bus_in)) && (carry_out == $past(carry_in)));

    // R7: zero flag reflects the result for codes 1..6
    a_r7_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_code != 3'd0) && (op_code != 3'd7)) |=> (zero_out == (acc_out == '0)));

    // R8: while driving, the bus carries the register value
    a_r8_drive_value: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (bus_drive == acc_out) && (op_code == 3'd7));

    // R9: no drive means a zero bus
    a_r9_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> (bus_drive == '0));

    // R10: inactive only on the no-op
    a_r10_active_nop: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (op_code == 3'd0));

endmodule

bind accum_pe accum_pe_checker #(.W(W)) u_accum_pe_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_code   (op_code),
    .bus_in    (bus_in),
    .carry_in  (carry_in),
    .zero_in   (zero_in),
    .acc_out   (acc_out),
    .carry_out (carry_out),
    .zero_out  (zero_out),
    .drive_en  (drive_en),
    .bus_drive (bus_drive),
    .active    (active)
);

// File: tb/test_accum_pe.sv
`timescale 1ns/1ps
module test_accum_pe;

    localparam int W = 16;
    localparam int NV = 19;

    typedef struct packed {
        logic [2:0]   op;
        logic [W-1:0] data;
        logic         cin;
        logic         zin;
        logic [W-1:0] exp_acc;
        logic         exp_c;
        logic         exp_z;
    } vec_t;

    // Chained vectors starting from the reset state (acc 0).
    localparam vec_t VECS [NV] = '{
        '{3'd4, 16'h1234, 1'b0, 1'b0, 16'h1234, 1'b0, 1'b0}, // R6 load
        '{3'd5, 16'hEDCC, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1}, // R3 exact wrap
        '{3'd5, 16'h0001, 1'b1, 1'b0, 16'h0002, 1'b0, 1'b0}, // R3 carry-in
        '{3'd2, 16'h0001, 1'b1, 1'b0, 16'h0001, 1'b1, 1'b0}, // R4 no borrow
        '{3'd2, 16'h0002, 1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b0}, // R4 borrow
        '{3'd2, 16'h7FFF, 1'b0, 1'b1, 16'h7FFF, 1'b1, 1'b0}, // R4 carry 0 in
        '{3'd3, 16'h0000, 1'b1, 1'b0, 16'hBFFF, 1'b1, 1'b0}, // R5 carry in 1
        '{3'd3, 16'hFFFF, 1'b0, 1'b1, 16'h5FFF, 1'b1, 1'b0}, // R5 carry in 0
        '{3'd1, 16'h5FFF, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1}, // R6 xor to zero
        '{3'd0, 16'hFFFF, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b1}, // R2 hold
        '{3'd4, 16'hA5A5, 1'b1, 1'b1, 16'hA5A5, 1'b1, 1'b0}, // R7 zin ignored
        '{3'd6, 16'h5A5A, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1}, // R6 and
        '{3'd4, 16'h0001, 1'b0, 1'b0, 16'h0001, 1'b0, 1'b0}, // R6 load
        '{3'd3, 16'h1234, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1}, // R5 rotate to zero
        '{3'd4, 16'hF00F, 1'b1, 1'b0, 16'hF00F, 1'b1, 1'b0}, // R6 load
        '{3'd7, 16'h1111, 1'b0, 1'b1, 16'hF00F, 1'b0, 1'b1}, // R8 store
        '{3'd1, 16'h0FF0, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b0}, // R7 xor
        '{3'd0, 16'h0000, 1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b0}, // R2 hold
        '{3'd5, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1}  // R3 wrap by carry
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_code = 3'd0;
    logic [W-1:0] bus_in = '0;
    logic         carry_in = 1'b0;
    logic         zero_in = 1'b0;
    logic [W-1:0] acc_out;
    logic         carry_out;
    logic         zero_out;
    logic         drive_en;
    logic [W-1:0] bus_drive;
    logic         active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    accum_pe #(.W(W)) i_accum_pe (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_code   (op_code),
        .bus_in    (bus_in),
        .carry_in  (carry_in),
        .zero_in   (zero_in),
        .acc_out   (acc_out),
        .carry_out (carry_out),
        .zero_out  (zero_out),
        .drive_en  (drive_en),
        .bus_drive (bus_drive),
        .active    (active)
    );

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R6";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R3";
            3'd6: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        logic [W-1:0] prev_acc;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "acc after reset", {1'b0, acc_out}, '0);
        check("R1", "flags after reset", {{(W-1){1'b0}}, carry_out, zero_out}, '0);
        rst_n = 1'b1;
        prev_acc = '0;
        for (int k = 0; k < NV; k++) begin
            op_code  = VECS[k].op;
            bus_in   = VECS[k].data;
            carry_in = VECS[k].cin;
            zero_in  = VECS[k].zin;
            #1;
            // R8 / R9: bus gating in the same cycle
            if (VECS[k].op == 3'd7) begin
                check("R8", "drive_en", {{W{1'b0}}, drive_en}, 17'd1);
                check("R8", "bus_drive", {1'b0, bus_drive}, {1'b0, prev_acc});
            end else begin
                check("R9", "drive_en", {{W{1'b0}}, drive_en}, 17'd0);
                check("R9", "bus_drive", {1'b0, bus_drive}, '0);
            end
            // R10: activity
            check("R10", "active", {{W{1'b0}}, active}, {{W{1'b0}}, (VECS[k].op != 3'd0)});
            @(negedge clk);
            check(req_of(VECS[k].op), "acc", {1'b0, acc_out}, {1'b0, VECS[k].exp_acc});
            check(req_of(VECS[k].op), "carry", {{W{1'b0}}, carry_out}, {{W{1'b0}}, VECS[k].exp_c});
            check("R7", "zero", {{W{1'b0}}, zero_out}, {{W{1'b0}}, VECS[k].exp_z});
            prev_acc = VECS[k].exp_acc;
        end
        // Directed: load a nonzero value, then reset during a load (R1).
        op_code = 3'd4; bus_in = 16'hC3C3; carry_in = 1'b1; zero_in = 1'b1;
        @(negedge clk);
        check("R6", "acc before reset", {1'b0, acc_out}, {1'b0, 16'hC3C3});
        rst_n = 1'b0; bus_in = 16'h1234;
        @(negedge clk);
        check("R1", "acc cleared under load", {1'b0, acc_out}, '0);
        check("R1", "flags cleared", {{(W-1){1'b0}}, carry_out, zero_out}, '0);
        rst_n = 1'b1;
        // R10: every non-zero code is active
        for (int c = 1; c < 8; c++) begin
            op_code = 3'(c);
            #0.5;
            check("R10", "active per code", {{W{1'b0}}, active}, 17'd1);
        end
        op_code = 3'd0;
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule